// File: doc/BRIEF.md
# Four-Bank Word-Interleaved Block Read Memory

This block is a read-only memory subsystem made of four independent banks, each one data word wide, sitting behind a single one-word return bus. It serves cache-block style reads of 1, 2 or 4 consecutive words. The requester presents a word address and a length code. The block spends a fixed number of cycles sending the address, then starts every bank the block needs in the same cycle. After the bank access latency, it returns the words one at a time in increasing address order, each word taking a fixed transfer slot on the bus.

A word lives in the bank selected by its address modulo four, at a row equal to the address divided by four. Because the banks of one block are accessed together, a block costs one address time, one access time and one transfer slot per word. A serial design would instead pay a full access per word. A bank also needs recovery time before it can start again. A request whose bank has started too recently therefore waits, so the interleaving does not help repeated accesses to one bank. The bank contents are preset at reset from a fixed formula that stands in for stored data.

Top module: `ilv_mem_top`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, rd_valid is 0 and rd_done is 0.
- R2: Word address a is held in bank a mod 4 at row a div 4. After reset, its value is the low 16 bits of (a * 0x9E37) XOR 0x5A5A.
- R3: req_lsz selects the block length: code 0 gives 1 word, code 1 gives 2 words, and codes 2 and 3 both give 4 words. Each word raises rd_valid for exactly one cycle, with rd_data carrying that word, in increasing address order.
- R4: The block starts at req_addr with its low log2(length) bits cleared. Those low bits never shift or reorder the returned words.
- R5: When the needed banks are free, word i of a block (counting from 0) appears 4 + 24 + 4*(i+1) cycles after the accepting clock edge. A block therefore takes 32, 36 or 44 cycles for 1, 2 or 4 words. Consecutive words are 4 cycles apart.
- R6: rd_done is 1 in the cycle of the last word of a block and 0 in every other cycle.
- R7: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the cycle in which rd_done is shown, and is 1 again in that cycle.
- R8: A bank starts a new access no sooner than 36 cycles (access plus recovery) after its previous start. The banks of a block start together at the later of 4 cycles after acceptance and the earliest start allowed for every needed bank. All word times of R5 shift by that wait.
- R9: req_valid raised while req_ready is 0 is ignored: it produces no words and leaves the current block's words and timing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W (7) | Word address of the block |
| req_lsz | input | 2 | Block length code (0: 1 word, 1: 2 words, 2 or 3: 4 words) |
| rd_valid | output | 1 | One-cycle strobe marking a returned word |
| rd_data | output | DATA_W (16) | Returned word |
| rd_done | output | 1 | Strobe with the last word of a block |

## Verification
The bench builds the block with its defaults: 16-bit words, a 7-bit word address, 4 banks, 4/24/4 cycles for address, access and transfer, and 12 recovery cycles. That gives a 36-cycle bank cycle. With a 36-cycle bank cycle, one-word requests issued back to back reach a still-recovering bank, so the stall path and its exact length are exercised alongside the no-stall timing of every block length. The small address space lets the bench read the highest aligned block, and the preset contents give every word a distinct value, so any error in bank or row selection or in word ordering shows in the data.

// File: rtl/ilv_pkg.sv
// Shared definitions for the interleaved block read memory.
// Assumes: fill values are a pure function of the word address.
package ilv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_ACC,
        S_XFER
    } seq_state_t;

    // Preset content of word address a (truncated by the caller).
    function automatic logic [31:0] fill_word(input int a, input logic [31:0] mix,
                                              input logic [31:0] seed);
        return (32'(a) * mix) ^ seed;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
// One word-wide memory bank. Holds every word whose address modulo
// NUM_BANKS equals BANK_ID, preset at reset. A start pulse latches the
// addressed row into q and makes the bank busy for BUSY_CYC cycles.
// Assumes: start is only raised while busy is low.
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ROW_W     = 5,
    parameter int          NUM_BANKS = 4,
    parameter int          BANK_ID   = 0,
    parameter int          BUSY_CYC  = 36,
    parameter logic [31:0] MIX       = 32'h9E37,
    parameter logic [31:0] SEED      = 32'h5A5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ROW_W-1:0]  row,
    output logic              busy,
    output logic [DATA_W-1:0] q
);
    localparam int ROWS   = 1 << ROW_W;
    localparam int BCNT_W = $clog2(BUSY_CYC + 1);

    logic [DATA_W-1:0] cells [ROWS];
    logic [BCNT_W-1:0] bcnt;

    // Preset the storage array from the fill formula.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= DATA_W'(fill_word(r * NUM_BANKS + BANK_ID, MIX, SEED));
            end
        end
    end

    // Latch the addressed word when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (start) begin
            q <= cells[row];
        end
    end

    // Count down the bank cycle (access plus recovery).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
        end else if (start) begin
            bcnt <= BCNT_W'(BUSY_CYC - 1);
        end else if (bcnt != '0) begin
            bcnt <= bcnt - 1'b1;
        end
    end

    assign busy = (bcnt != '0);

    // R8: a bank is never restarted inside its bank cycle.
    a_r8_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/ilv_seq.sv
// Request sequencer: accepts one block at a time, runs the address phase,
// waits for the needed banks, starts them together, waits out the access
// and then paces the word transfers.
// Assumes: block never crosses a row (aligned, length <= NUM_BANKS).
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int NUM_BANKS = 4,
    parameter int LSZ_W     = 2,
    parameter int ADDR_CYC  = 4,
    parameter int ACC_CYC   = 24,
    parameter int XFER_CYC  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [LSZ_W-1:0]                  req_lsz,
    input  logic [NUM_BANKS-1:0]              bank_busy,
    output logic                              req_ready,
    output logic [NUM_BANKS-1:0]              bank_start,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] row,
    output logic                              take,
    output logic [$clog2(NUM_BANKS)-1:0]      take_bank,
    output logic                              take_last
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int N_W    = BANK_W + 1;
    localparam int MAXC   = ADDR_CYC + ACC_CYC + XFER_CYC;
    localparam int CNT_W  = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ADDR_LD = CNT_W'(ADDR_CYC - 1);
    localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_CYC - 1);
    localparam logic [CNT_W-1:0] XFER_LD = CNT_W'(XFER_CYC - 1);

    seq_state_t          state;
    logic [CNT_W-1:0]    cnt;
    logic [ADDR_W-1:0]   base_q;
    logic [N_W-1:0]      n_q;
    logic [BANK_W-1:0]   idx_q;

    logic [LSZ_W-1:0]    lsz_eff;
    logic [N_W-1:0]      n_in;
    logic [ADDR_W-1:0]   base_in;
    logic [NUM_BANKS-1:0] need;
    logic                conflict;
    logic                launch;

    // Clamp the length code and align the incoming address.
    always_comb begin
        lsz_eff = (int'(req_lsz) > BANK_W) ? LSZ_W'(BANK_W) : req_lsz;
        n_in    = N_W'(1) << lsz_eff;
        base_in = req_addr & ~(ADDR_W'(n_in) - ADDR_W'(1));
    end

    // Banks covered by the latched block.
    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            need[b] = (b >= int'(base_q[BANK_W-1:0])) &&
                      (b < int'(base_q[BANK_W-1:0]) + int'(n_q));
        end
    end

    // Start the banks once the address is sent and none of them is busy.
    always_comb begin
        conflict   = |(need & bank_busy);
        launch     = ((state == S_ADDR && cnt == '0) || state == S_WAIT) && !conflict;
        bank_start = launch ? need : '0;
    end

    assign req_ready = (state == S_IDLE);
    assign row       = base_q[ADDR_W-1:BANK_W];
    assign take      = (state == S_XFER) && (cnt == '0);
    assign take_bank = base_q[BANK_W-1:0] + idx_q;
    assign take_last = ({1'b0, idx_q} == n_q - N_W'(1));

    // Phase sequencing and per-phase cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            base_q <= '0;
            n_q    <= N_W'(1);
            idx_q  <= '0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    state  <= S_ADDR;
                    cnt    <= ADDR_LD;
                    base_q <= base_in;
                    n_q    <= n_in;
                end
                S_ADDR: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (launch) begin
                    state <= S_ACC;
                    cnt   <= ACC_LD;
                end else begin
                    state <= S_WAIT;
                end
                S_WAIT: if (launch) begin
                    state <= S_ACC;
                    cnt   <= ACC_LD;
                end
                S_ACC: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    state <= S_XFER;
                    cnt   <= XFER_LD;
                    idx_q <= '0;
                end
                S_XFER: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (take_last) begin
                    state <= S_IDLE;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    cnt   <= XFER_LD;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R7: an accepted request closes the request port next cycle.
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: no transfer beyond the block length.
    a_r3_idx_in_block: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ({1'b0, idx_q} < n_q));

endmodule

// File: rtl/ilv_mem_top.sv
// Four-bank word-interleaved block read memory. Bank = address mod
// NUM_BANKS, row = address div NUM_BANKS. Words of a block return on one
// registered bus in address order, one per transfer slot.
// Assumes: requester honours req_ready; block lengths are powers of two.
module ilv_mem_top #(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 7,
    parameter int          NUM_BANKS = 4,
    parameter int          ADDR_CYC  = 4,
    parameter int          ACC_CYC   = 24,
    parameter int          XFER_CYC  = 4,
    parameter int          RECOV_CYC = 12,
    parameter logic [31:0] FILL_MIX  = 32'h9E37,
    parameter logic [31:0] FILL_SEED = 32'h5A5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_lsz,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;

    logic [NUM_BANKS-1:0] bank_busy;
    logic [NUM_BANKS-1:0] bank_start;
    logic [ROW_W-1:0]     row;
    logic                 take;
    logic [BANK_W-1:0]    take_bank;
    logic                 take_last;
    logic [DATA_W-1:0]    bank_q [NUM_BANKS];

    ilv_seq #(
        .ADDR_W   (ADDR_W),
        .NUM_BANKS(NUM_BANKS),
        .LSZ_W    (2),
        .ADDR_CYC (ADDR_CYC),
        .ACC_CYC  (ACC_CYC),
        .XFER_CYC (XFER_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_lsz   (req_lsz),
        .bank_busy (bank_busy),
        .req_ready (req_ready),
        .bank_start(bank_start),
        .row       (row),
        .take      (take),
        .take_bank (take_bank),
        .take_last (take_last)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W   (DATA_W),
            .ROW_W    (ROW_W),
            .NUM_BANKS(NUM_BANKS),
            .BANK_ID  (b),
            .BUSY_CYC (ACC_CYC + RECOV_CYC),
            .MIX      (FILL_MIX),
            .SEED     (FILL_SEED)
        ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .start(bank_start[b]),
            .row  (row),
            .busy (bank_busy[b]),
            .q    (bank_q[b])
        );
    end

    // Register the returned word and its strobes onto the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_done  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            rd_done  <= take && take_last;
            if (take) begin
                rd_data <= bank_q[take_bank];
            end
        end
    end

    // R6: completion only ever accompanies a word.
    a_r6_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> rd_valid);

    // R5: words are separated by a full transfer slot.
    a_r5_word_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: tb/ilv_mem_top_test.sv
// Directed bench for the interleaved block read memory.
module ilv_mem_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [6:0]  req_addr = '0;
    logic [1:0]  req_lsz = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        rd_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_start [4] = '{-1000, -1000, -1000, -1000};

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ilv_mem_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_addr (req_addr),
        .req_lsz  (req_lsz),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_done  (rd_done)
    );

    function automatic logic [15:0] ref_word(input int a);
        logic [31:0] v;
        v = (32'(a) * 32'h9E37) ^ 32'h5A5A;
        return v[15:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one block request and check every returned word.
    task automatic run_req(input int addr, input int lsz, input string req, input bit junk);
        int n, base, acc, start, tmo;
        n    = (lsz >= 2) ? 4 : (1 << lsz);
        base = addr & ~(n - 1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 7'(addr);
        req_lsz   = 2'(lsz);
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7", "ready after accept", int'(req_ready), 0);
        start = acc + 4;
        for (int k = 0; k < n; k++) begin
            int b = (base + k) % 4;
            if (last_start[b] + 36 > start) start = last_start[b] + 36;
        end
        for (int k = 0; k < n; k++) last_start[(base + k) % 4] = start;
        for (int i = 0; i < n; i++) begin
            tmo = 0;
            if (junk && i == 0) begin
                for (int j = 0; j < 3; j++) begin
                    req_valid = 1'b1;
                    req_addr  = 7'(addr + 40);
                    req_lsz   = 2'd0;
                    @(negedge clk);
                end
                req_valid = 1'b0;
            end
            while (!rd_valid && tmo < 400) begin
                @(negedge clk);
                tmo++;
            end
            check(cyc == start + 24 + 4 * (i + 1), {req, " R5"}, "word time",
                  cyc - acc, start + 24 + 4 * (i + 1) - acc);
            check(rd_data == ref_word(base + i), {req, " R2 R3"}, "word data",
                  int'(rd_data), int'(ref_word(base + i)));
            check(rd_done == (i == n - 1), {req, " R6"}, "done flag",
                  int'(rd_done), int'(i == n - 1));
            if (i == n - 1) begin
                check(req_ready == 1'b1, "R7", "ready with last word", int'(req_ready), 1);
            end else begin
                check(req_ready == 1'b0, "R7", "ready mid block", int'(req_ready), 0);
            end
            @(negedge clk);
            check(rd_valid == 1'b0, {req, " R3"}, "single-cycle strobe", int'(rd_valid), 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
        check(rd_valid == 1'b0, "R1", "valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(rd_valid == 1'b0 && rd_done == 1'b0, "R1", "strobes after reset",
              int'(rd_valid) + int'(rd_done), 0);
    endtask

    task automatic t_single_words();
        run_req(0, 0, "R2 single", 1'b0);
        run_req(5, 0, "R2 single", 1'b0);
        run_req(126, 0, "R2 single", 1'b0);
    endtask

    task automatic t_pairs_and_quads();
        run_req(2, 1, "R3 R4 pair", 1'b0);
        run_req(11, 1, "R3 R4 pair", 1'b0);
        run_req(8, 2, "R3 quad", 1'b0);
        run_req(30, 3, "R3 R4 quad code3", 1'b0);
        run_req(127, 2, "R4 top quad", 1'b0);
    endtask

    task automatic t_same_bank_stall();
        run_req(33, 0, "R8 first", 1'b0);
        run_req(37, 0, "R8 same bank", 1'b0);
        run_req(38, 0, "R8 other bank", 1'b0);
        run_req(41, 1, "R8 pair overlap", 1'b0);
    endtask

    task automatic t_ignored_request();
        run_req(64, 2, "R9 busy request", 1'b1);
        repeat (60) begin
            @(negedge clk);
            if (rd_valid) break;
        end
        check(rd_valid == 1'b0, "R9", "no word from ignored request", int'(rd_valid), 0);
        check(req_ready == 1'b1, "R9", "idle after ignored request", int'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_single_words();
        t_pairs_and_quads();
        t_same_bank_stall();
        t_ignored_request();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule